// File: doc/BRIEF.md
# Dual-Format Serial Management Slave

This block is the slave end of a two-wire serial management bus. It runs on the management clock and watches a shared data line that an external pull-up holds high when idle. It understands two frame formats. Short frames carry a 5-bit register address. Extended frames carry a 5-bit device field and reach a 16-bit register space. The slave answers reads by driving the line during the turnaround and data phases. It accepts writes from the bus master into a small local register set.

A 16-bit address space cannot be named in a 5-bit field, so two short-format registers open a window into it. Short register 30 holds a 16-bit pointer. Short register 31 reads or writes the extended register that the pointer selects. Extended frames read through the same pointer. Their read-and-increment form also advances the pointer by one, so a master can walk a block of registers without rewriting the pointer.

The data line is split into a sampled input, a driven value and an output enable. A strap input sets the slave's bus address. A parameterised array of test registers stands behind a run of extended addresses.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is recognised only when a 0 start bit follows at least 32 consecutive 1 samples on the line. After a run of 31 ones, or with no preamble at all, the whole frame is ignored: nothing is driven and nothing is written.
- R2: On a read addressed to this slave, the line is released for the first turnaround bit and driven 0 for the second. The 16 data bits follow, most significant bit first. The line is released again from the bit after the last data bit, and it is never driven at any other time.
- R3: A short write (start bits 0,1, opcode 0,1, turnaround 1,0, then 16 data bits from the master, MSB first) to register 30 sets the 16-bit extended pointer. A short read (start 0,1, opcode 1,0) of register 30 returns the pointer. Other short addresses, apart from 30 and 31, read as 0 and discard writes.
- R4: A short read or write of register 31 reaches the extended register at the pointer. Extended addresses EXT_BASE to EXT_BASE+N_REGS-1 are backed by storage. Every other extended address reads 0 and discards writes.
- R5: An extended read (start 0,0, opcode 1,1) returns the register at the pointer and leaves the pointer unchanged, whatever the 5-bit device field holds.
- R6: An extended read-and-increment (start 0,0, opcode 1,0) returns the register at the pointer as it was before the frame, and adds one to the pointer within the same frame. Successive frames walk upward, past the end of the backed range into addresses that read 0.
- R7: When the 5-bit PHY address field differs from the strap input, the slave never drives the line and performs no write.
- R8: The start/opcode pairs short 0,0 and short 1,1, and extended 0,0 and extended 0,1, abort the frame. The rest of that frame has no effect, and a new preamble is needed before the next frame.
- R9: Line bits are sampled on the rising clock edge. The slave's output and enable change only after the falling edge, so they are stable across every rising edge.
- R10: After reset the pointer and all backed registers are 0 and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the bus master |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_strap | input | 5 | This slave's bus address |
| mdio_i | input | 1 | Sampled value of the shared data line |
| mdio_o | output | 1 | Value the slave drives onto the line |
| mdio_oe | output | 1 | Enable for the slave's line driver |

## Verification
Two actions share one rising edge. At the end of the address field of an extended read-and-increment, the block captures the read data and steps the pointer on the same edge. The bench provokes this with a run of read-and-increment frames. The run starts one address below the backed range and ends two past its top. Each frame's returned value is compared with a bench model that reads first and increments afterwards. A short read of register 30 then checks that the pointer moved exactly once per frame.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

    localparam int PRE_LEN = 32;
    localparam int ONES_W  = $clog2(PRE_LEN + 1);

    localparam logic [4:0] REG_PTR = 5'd30;
    localparam logic [4:0] REG_WIN = 5'd31;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_OP,
        PH_PHY,
        PH_REG,
        PH_TURN,
        PH_DATA
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [ONES_W-1:0]   ones;
        logic [3:0]          cnt;
        logic                ext;
        logic [1:0]          op;
        logic [4:0]          pa;
        logic [4:0]          ra;
        logic                hit;
        logic                rd;
        logic [15:0]         sh;
    } frame_s;

endpackage

// File: rtl/mdio_frame_rx.sv
`timescale 1ns/1ps
module mdio_frame_rx import mdio_mgmt_pkg::*; (
    input  logic        mdc,
    input  logic        rst_n,
    input  logic        mdio_in,
    input  logic [4:0]  strap,
    input  logic [15:0] ptr,
    input  logic [15:0] win_rdata,
    output logic        drv_en,
    output logic        drv_bit,
    output logic        ptr_wr,
    output logic        win_wr,
    output logic        ptr_inc,
    output logic [15:0] wdata
);

    frame_s s_d, s_q;

    logic [1:0]  op_n;
    logic [4:0]  pa_n;
    logic [4:0]  ra_n;
    logic        op_ok;
    logic [15:0] rd_val;

    assign op_n  = {s_q.op[0], mdio_in};
    assign pa_n  = {s_q.pa[3:0], mdio_in};
    assign ra_n  = {s_q.ra[3:0], mdio_in};
    assign op_ok = s_q.ext ? op_n[1] : (op_n == 2'b10 || op_n == 2'b01);
    assign wdata = {s_q.sh[14:0], mdio_in};

    always_comb begin
        if (s_q.ext)              rd_val = win_rdata;
        else if (ra_n == REG_PTR) rd_val = ptr;
        else if (ra_n == REG_WIN) rd_val = win_rdata;
        else                      rd_val = '0;
    end

    always_comb begin
        s_d     = s_q;
        ptr_wr  = 1'b0;
        win_wr  = 1'b0;
        ptr_inc = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (mdio_in) begin
                    if (s_q.ones != ONES_W'(PRE_LEN)) s_d.ones = s_q.ones + 1'b1;
                end else if (s_q.ones == ONES_W'(PRE_LEN)) begin
                    s_d.ph   = PH_START;
                    s_d.ones = '0;
                end else begin
                    s_d.ones = '0;
                end
            end
            PH_START: begin
                s_d.ext = ~mdio_in;
                s_d.ph  = PH_OP;
                s_d.cnt = '0;
            end
            PH_OP: begin
                s_d.op = op_n;
                if (s_q.cnt == 4'd1) begin
                    s_d.cnt = '0;
                    if (op_ok) begin
                        s_d.ph = PH_PHY;
                        s_d.rd = s_q.ext | (op_n == 2'b10);
                    end else begin
                        s_d.ph   = PH_IDLE;
                        s_d.ones = '0;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 4'd1;
                end
            end
            PH_PHY: begin
                s_d.pa = pa_n;
                if (s_q.cnt == 4'd4) begin
                    s_d.hit = (pa_n == strap);
                    s_d.ph  = PH_REG;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 4'd1;
                end
            end
            PH_REG: begin
                s_d.ra = ra_n;
                if (s_q.cnt == 4'd4) begin
                    s_d.ph  = PH_TURN;
                    s_d.cnt = '0;
                    if (s_q.rd) s_d.sh = rd_val;
                    ptr_inc = s_q.ext & ~s_q.op[0] & s_q.hit;
                end else begin
                    s_d.cnt = s_q.cnt + 4'd1;
                end
            end
            PH_TURN: begin
                if (s_q.cnt == 4'd1) begin
                    s_d.ph  = PH_DATA;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 4'd1;
                end
            end
            PH_DATA: begin
                s_d.sh = s_q.rd ? {s_q.sh[14:0], 1'b0} : wdata;
                if (s_q.cnt == 4'd15) begin
                    s_d.ph   = PH_IDLE;
                    s_d.ones = '0;
                    s_d.cnt  = '0;
                    if (!s_q.rd && s_q.hit) begin
                        ptr_wr = (s_q.ra == REG_PTR);
                        win_wr = (s_q.ra == REG_WIN);
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 4'd1;
                end
            end
            default: begin
                s_d.ph   = PH_IDLE;
                s_d.ones = '0;
            end
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) s_q <= frame_s'('0);
        else        s_q <= s_d;
    end

    assign drv_en  = s_q.hit & s_q.rd &
                     ((s_q.ph == PH_TURN && s_q.cnt == 4'd1) || s_q.ph == PH_DATA);
    assign drv_bit = (s_q.ph == PH_DATA) & s_q.sh[15];

    // R1: without a full preamble the parser stays idle
    a_r1_preamble_gate: assert property (@(posedge mdc) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && s_q.ones != ONES_W'(PRE_LEN)) |=> (s_q.ph == PH_IDLE));

    // R8: a bad start/opcode pair sends the parser back to preamble hunting
    a_r8_abort: assert property (@(posedge mdc) disable iff (!rst_n)
        (s_q.ph == PH_OP && s_q.cnt == 4'd1 && !op_ok) |=> (s_q.ph == PH_IDLE && s_q.ones == '0));

endmodule

// File: rtl/mdio_ext_bank.sv
`timescale 1ns/1ps
module mdio_ext_bank #(
    parameter int          N_REGS   = 8,
    parameter logic [15:0] EXT_BASE = 16'h9000
) (
    input  logic        mdc,
    input  logic        rst_n,
    input  logic        ptr_wr,
    input  logic        win_wr,
    input  logic        ptr_inc,
    input  logic [15:0] wdata,
    output logic [15:0] ptr,
    output logic [15:0] win_rdata
);

    localparam int IDX_W = $clog2(N_REGS);

    logic [15:0] ptr_d, ptr_q;
    logic [15:0] off;
    logic        in_rng;
    logic [N_REGS-1:0][15:0] regs_v;

    assign off    = ptr_q - EXT_BASE;
    assign in_rng = (off < 16'(N_REGS));

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_wr)       ptr_d = wdata;
        else if (ptr_inc) ptr_d = ptr_q + 16'd1;
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        logic [15:0] r_d, r_q;
        always_comb begin
            r_d = r_q;
            if (win_wr && in_rng && off[IDX_W-1:0] == IDX_W'(g)) r_d = wdata;
        end
        always_ff @(posedge mdc or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end
        assign regs_v[g] = r_q;
    end

    assign ptr       = ptr_q;
    assign win_rdata = in_rng ? regs_v[off[IDX_W-1:0]] : '0;

    // R6: the pointer only moves on a pointer write or an increment
    a_r6_ptr_hold: assert property (@(posedge mdc) disable iff (!rst_n)
        (!ptr_wr && !ptr_inc) |=> $stable(ptr_q));

    // R6: pointer write, window write and increment never coincide
    a_r6_ctl_excl: assert property (@(posedge mdc) disable iff (!rst_n)
        $onehot0({ptr_wr, win_wr, ptr_inc}));

endmodule

// File: rtl/mdio_line_drv.sv
`timescale 1ns/1ps
module mdio_line_drv (
    input  logic mdc,
    input  logic rst_n,
    input  logic drv_en,
    input  logic drv_bit,
    output logic oe,
    output logic dout
);

    typedef struct packed {
        logic oe;
        logic o;
    } line_s;

    line_s l_d, l_q;

    always_comb begin
        l_d.oe = drv_en;
        l_d.o  = drv_en & drv_bit;
    end

    always_ff @(negedge mdc or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign oe   = l_q.oe;
    assign dout = l_q.o;

    // run-length of driven bits, kept only for the checks below
    logic [4:0] run_d, run_q;
    always_comb run_d = l_q.oe ? ((run_q == 5'd31) ? run_q : run_q + 5'd1) : 5'd0;
    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R2: the first driven bit of a response is the turnaround zero
    a_r2_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(l_q.oe) |-> !l_q.o);

    // R2: one response drives at most 17 bits (turnaround zero plus 16 data)
    a_r2_drive_len: assert property (@(posedge mdc) disable iff (!rst_n)
        l_q.oe |-> (run_q < 5'd17));

endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave #(
    parameter int          N_REGS   = 8,
    parameter logic [15:0] EXT_BASE = 16'h9000
) (
    input  logic       mdc,
    input  logic       rst_n,
    input  logic [4:0] phy_addr_strap,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe
);

    logic        drv_en, drv_bit;
    logic        ptr_wr, win_wr, ptr_inc;
    logic [15:0] wdata, ptr, win_rdata;

    mdio_frame_rx u_rx (
        .mdc       (mdc),
        .rst_n     (rst_n),
        .mdio_in   (mdio_i),
        .strap     (phy_addr_strap),
        .ptr       (ptr),
        .win_rdata (win_rdata),
        .drv_en    (drv_en),
        .drv_bit   (drv_bit),
        .ptr_wr    (ptr_wr),
        .win_wr    (win_wr),
        .ptr_inc   (ptr_inc),
        .wdata     (wdata)
    );

    mdio_ext_bank #(.N_REGS(N_REGS), .EXT_BASE(EXT_BASE)) u_bank (
        .mdc       (mdc),
        .rst_n     (rst_n),
        .ptr_wr    (ptr_wr),
        .win_wr    (win_wr),
        .ptr_inc   (ptr_inc),
        .wdata     (wdata),
        .ptr       (ptr),
        .win_rdata (win_rdata)
    );

    mdio_line_drv u_drv (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .drv_en  (drv_en),
        .drv_bit (drv_bit),
        .oe      (mdio_oe),
        .dout    (mdio_o)
    );

endmodule

// File: tb/test_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module test_mdio_mgmt_slave;

    localparam int          N    = 8;
    localparam logic [15:0] BASE = 16'h9000;
    localparam logic [4:0]  ME   = 5'h0B;

    logic mdc = 1'b0;
    logic rst_n = 1'b0;
    logic m_oe = 1'b0;
    logic m_val = 1'b1;
    logic mdio_o, mdio_oe;
    logic line;

    always #2 mdc = ~mdc;

    assign line = mdio_oe ? mdio_o : (m_oe ? m_val : 1'b1);

    mdio_mgmt_slave #(.N_REGS(N), .EXT_BASE(BASE)) i_mdio_mgmt_slave (
        .mdc            (mdc),
        .rst_n          (rst_n),
        .phy_addr_strap (ME),
        .mdio_i         (line),
        .mdio_o         (mdio_o),
        .mdio_oe        (mdio_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_unstab = 0;
    bit done = 1'b0;

    logic [15:0] mdl [N];
    logic [15:0] mptr;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic b);
        @(negedge mdc);
        #0.5;
        m_oe  = 1'b1;
        m_val = b;
    endtask

    task automatic get(output logic v, output logic oe);
        logic e1, o1;
        @(negedge mdc);
        #0.5;
        m_oe = 1'b0;
        #1.2;
        e1 = mdio_oe;
        o1 = mdio_o;
        @(posedge mdc);
        #1;
        v  = line;
        oe = mdio_oe;
        if (e1 !== mdio_oe || o1 !== mdio_o) n_unstab++;
    endtask

    task automatic frame(input int npre, input bit lead0, input logic s2, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra, input bit rd,
                         input logic [15:0] wd, input bit exp_drv,
                         output logic [15:0] q, output int bad);
        logic v, oe;
        bad = 0;
        q = '0;
        if (lead0) put(1'b0);
        repeat (npre) put(1'b1);
        put(1'b0);
        put(s2);
        put(op[1]);
        put(op[0]);
        for (int i = 4; i >= 0; i--) put(pa[i]);
        for (int i = 4; i >= 0; i--) put(ra[i]);
        if (rd) begin
            get(v, oe);
            if (oe !== 1'b0) bad++;
            get(v, oe);
            if (oe !== exp_drv || (exp_drv && v !== 1'b0)) bad++;
            for (int i = 15; i >= 0; i--) begin
                get(v, oe);
                q[i] = v;
                if (oe !== exp_drv) bad++;
            end
            get(v, oe);
            if (oe !== 1'b0) bad++;
        end else begin
            put(1'b1);
            put(1'b0);
            for (int i = 15; i >= 0; i--) put(wd[i]);
            put(1'b1);
        end
    endtask

    task automatic sw(input logic [4:0] ra, input logic [15:0] d);
        logic [15:0] q;
        int bad;
        frame(32, 1'b0, 1'b1, 2'b01, ME, ra, 1'b0, d, 1'b0, q, bad);
    endtask

    task automatic sr(input logic [4:0] ra, output logic [15:0] q, output int bad);
        frame(32, 1'b0, 1'b1, 2'b10, ME, ra, 1'b1, 16'h0, 1'b1, q, bad);
    endtask

    task automatic er(input bit inc, input logic [4:0] dev, output logic [15:0] q, output int bad);
        frame(32, 1'b0, 1'b0, inc ? 2'b10 : 2'b11, ME, dev, 1'b1, 16'h0, 1'b1, q, bad);
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'hA5C0 ^ (16'(i) * 16'h1111);
    endfunction

    function automatic logic [15:0] model_rd(input logic [15:0] p);
        logic [15:0] o;
        o = p - BASE;
        return (o < 16'(N)) ? mdl[o[2:0]] : 16'h0;
    endfunction

    initial begin
        logic [15:0] q;
        int bad;

        for (int i = 0; i < N; i++) mdl[i] = '0;
        mptr = '0;

        repeat (3) @(posedge mdc);
        #1;
        chk(mdio_oe === 1'b0, "R10 line released in reset", 32'(mdio_oe), 0);
        @(negedge mdc);
        rst_n = 1'b1;

        // R10: reset state seen through the bus
        sr(5'd30, q, bad);
        chk(q === 16'h0 && bad == 0, "R10 pointer after reset", q, 0);
        sr(5'd31, q, bad);
        chk(q === 16'h0 && bad == 0, "R10 register after reset", q, 0);

        // R3/R4: fill the backed range through the window
        for (int i = 0; i < N; i++) begin
            sw(5'd30, BASE + 16'(i));
            mptr = BASE + 16'(i);
            sw(5'd31, pat(i));
            mdl[i] = pat(i);
            sr(5'd30, q, bad);
            chk(q === mptr && bad == 0, "R3 pointer readback", q, mptr);
        end

        // R4/R2: read back every register via register 31
        for (int i = N - 1; i >= 0; i--) begin
            sw(5'd30, BASE + 16'(i));
            mptr = BASE + 16'(i);
            sr(5'd31, q, bad);
            chk(q === mdl[i], "R4 window read", q, mdl[i]);
            chk(bad == 0, "R2 turnaround and drive window", 32'(bad), 0);
        end

        // R3: other short addresses read 0 and drop writes
        sw(5'd7, 16'hFFFF);
        sr(5'd7, q, bad);
        chk(q === 16'h0 && bad == 0, "R3 unmapped short register", q, 0);
        sr(5'd0, q, bad);
        chk(q === 16'h0 && bad == 0, "R3 short register 0", q, 0);

        // R5: extended read, any device field, pointer unchanged
        sw(5'd30, BASE + 16'd3);
        mptr = BASE + 16'd3;
        for (int d = 0; d < 32; d += 7) begin
            er(1'b0, 5'(d), q, bad);
            chk(q === mdl[3] && bad == 0, "R5 extended read", q, mdl[3]);
        end
        sr(5'd30, q, bad);
        chk(q === mptr, "R5 pointer unchanged", q, mptr);

        // R6: read-and-increment walk across both ends of the range
        sw(5'd30, BASE - 16'd1);
        mptr = BASE - 16'd1;
        for (int i = 0; i < N + 3; i++) begin
            logic [15:0] e;
            e = model_rd(mptr);
            er(1'b1, 5'd0, q, bad);
            chk(q === e && bad == 0, "R6 read-increment data", q, e);
            mptr = mptr + 16'd1;
        end
        sr(5'd30, q, bad);
        chk(q === mptr, "R6 pointer advanced once per frame", q, mptr);

        // R4: outside the backed range reads 0, writes dropped
        sw(5'd30, BASE + 16'(N));
        sw(5'd31, 16'hDEAD);
        sr(5'd31, q, bad);
        chk(q === 16'h0, "R4 out-of-range read", q, 0);
        sw(5'd30, BASE - 16'd1);
        sw(5'd31, 16'hBEEF);
        sr(5'd31, q, bad);
        chk(q === 16'h0, "R4 below-range read", q, 0);
        sw(5'd30, BASE + 16'(N - 1));
        mptr = BASE + 16'(N - 1);
        sr(5'd31, q, bad);
        chk(q === mdl[N-1], "R4 top register intact", q, mdl[N-1]);

        // R7: every foreign PHY address is ignored
        for (int p = 0; p < 32; p++) begin
            if (5'(p) != ME) begin
                frame(32, 1'b0, 1'b1, 2'b01, 5'(p), 5'd30, 1'b0, 16'h1234, 1'b0, q, bad);
                frame(32, 1'b0, 1'b1, 2'b10, 5'(p), 5'd31, 1'b1, 16'h0, 1'b0, q, bad);
                chk(bad == 0 && q === 16'hFFFF, "R7 no drive on foreign address", q, 16'hFFFF);
            end
        end
        sr(5'd30, q, bad);
        chk(q === mptr, "R7 no write on foreign address", q, mptr);

        // R1: 31 ones is too short, no preamble at all is ignored
        frame(31, 1'b1, 1'b1, 2'b01, ME, 5'd30, 1'b0, 16'h1111, 1'b0, q, bad);
        frame(31, 1'b1, 1'b1, 2'b10, ME, 5'd30, 1'b1, 16'h0, 1'b0, q, bad);
        chk(bad == 0 && q === 16'hFFFF, "R1 short preamble read ignored", q, 16'hFFFF);
        frame(0, 1'b0, 1'b1, 2'b01, ME, 5'd30, 1'b0, 16'h2222, 1'b0, q, bad);
        sr(5'd30, q, bad);
        chk(q === mptr, "R1 short preamble write ignored", q, mptr);
        frame(32, 1'b1, 1'b1, 2'b01, ME, 5'd30, 1'b0, BASE + 16'd2, 1'b0, q, bad);
        mptr = BASE + 16'd2;
        sr(5'd31, q, bad);
        chk(q === mdl[2] && bad == 0, "R1 exactly 32 ones accepted", q, mdl[2]);

        // R8: invalid start/opcode pairs abort
        for (int k = 0; k < 4; k++) begin
            logic       s2;
            logic [1:0] op;
            s2 = (k < 2);
            op = (k == 0) ? 2'b11 : (k == 1) ? 2'b00 : (k == 2) ? 2'b00 : 2'b01;
            frame(32, 1'b0, s2, op, ME, 5'd30, 1'b0, 16'h3333, 1'b0, q, bad);
            frame(32, 1'b0, s2, op, ME, 5'd31, 1'b1, 16'h0, 1'b0, q, bad);
            chk(bad == 0 && q === 16'hFFFF, "R8 aborted frame not answered", q, 16'hFFFF);
        end
        sr(5'd30, q, bad);
        chk(q === mptr, "R8 aborted writes dropped", q, mptr);

        // R9: output never moved across a rising edge
        chk(n_unstab == 0, "R9 output stable at rising edge", 32'(n_unstab), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule